// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous client and an external asynchronous static RAM of 128K bytes. The client raises a request with a write flag, an address and write data. The block then runs one access on the memory pins. It holds every strobe for a whole number of clock cycles, and that number is worked out when the design is elaborated from the clock period and from the memory speed grade (12, 15 or 20 ns). A read returns its byte on `rdata` with a one-cycle `done` pulse. A write also ends with a `done` pulse.

Only one access is in flight at a time. `ready` marks the cycles in which a new request is taken. During a write, output enable stays high, so the memory's short minimum write pulse applies. The data bus is split into a drive value and a drive enable. The enable is sequenced so that the controller never drives the bus while the memory's own outputs might still be on.

Top module: `asram_ctrl`

## Requirements
- R1: While idle and during reset, chip select, output enable and write enable are high, the data bus drive enable is low, `ready` is high and `done` is low.
- R2: A read holds chip select and output enable low and write enable high for ACC cycles. ACC is the larger of the access time and the output-enable access time divided by the clock period, rounded up (2 cycles at 10 ns and grade 12). The data bus is not driven during these cycles.
- R3: A write holds chip select and write enable low and output enable high for WP cycles. WP is the largest of the write pulse, data setup and address-to-end-of-write limits divided by the clock period, rounded up (1 cycle at 10 ns and grade 12).
- R4: Read data is sampled on the clock edge that ends the last access cycle and appears on `rdata` in the following cycle.
- R5: `done` is high for exactly one cycle: the cycle right after the last read access cycle or the last write pulse cycle.
- R6: After a read, all strobes stay high with no bus drive for REL cycles (output turn-off time over the clock period, rounded up, at least 1; 1 at 10 ns and grade 12). `ready` stays low from acceptance until REL has elapsed.
- R7: A write that follows a read, with any number of idle cycles between them, starts with one turnaround cycle in which all strobes are high and the bus is not driven.
- R8: The bus is driven only during the write pulse and the write recovery that follows it. The driven value is the write data taken when the request was accepted. The bus is never driven in a cycle where output enable is low.
- R9: After the write pulse, all strobes are high for WREC cycles while the drive is held. WREC is the write cycle time over the clock period, rounded up, minus WP, and is at least 1 (1 at 10 ns and grade 12). `ready` stays low until WREC has elapsed.
- R10: A request raised while `ready` is low is ignored unless it is still high in an idle cycle. A request held high is accepted again in each idle cycle.
- R11: `mem_addr` holds the address taken at acceptance for the whole access and its recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `ready` is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Idle; a request is taken at the next edge |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read byte |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
The properties assume that `req`, `wr`, `addr` and `wdata` change only away from the active clock edge. They also assume that the memory model drives `mem_dq_in` only while the read strobes are decoded. The stimulus changes inputs on the falling edge. Its memory model returns valid data only from the second cycle of output enable being low, so a capture taken one edge early reads a junk value. The bench holds requests across busy cycles and drops them before idle, which keeps the ignored-request case separate from the re-acceptance case.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_TURN, ST_RD, ST_RDREL, ST_WR, ST_WRREC
   } asram_state_e;

   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Limits in ns for each supported speed grade
   function automatic int lim_access(input int g);
      return g;
   endfunction

   function automatic int lim_oe_valid(input int g);
      return (g == 20) ? 8 : (g == 15) ? 7 : 6;
   endfunction

   function automatic int lim_oe_off(input int g);
      return (g == 20) ? 7 : 5;
   endfunction

   function automatic int lim_wr_pulse(input int g);
      return (g == 20) ? 15 : (g == 15) ? 12 : 8;
   endfunction

   function automatic int lim_data_setup(input int g);
      return (g == 20) ? 9 : (g == 15) ? 8 : 6;
   endfunction

   function automatic int lim_addr_to_end(input int g);
      return (g == 20) ? 15 : (g == 15) ? 12 : 8;
   endfunction

   function automatic int lim_wr_cycle(input int g);
      return g;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
   import asram_pkg::*;
#(
   parameter int ACC_C  = 2,
   parameter int REL_C  = 1,
   parameter int TURN_C = 1,
   parameter int WP_C   = 1,
   parameter int WREC_C = 1,
   parameter int CW     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          wr,
   input  logic          tmr_zero,
   output asram_state_e  state,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output logic          accept,
   output logic          capture,
   output logic          done_set
);

   asram_state_e st_q, st_d;
   logic         rd_last_q;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE: if (req) begin
            tmr_load = 1'b1;
            if (wr && rd_last_q) begin
               st_d    = ST_TURN;
               tmr_val = CW'(TURN_C - 1);
            end else if (wr) begin
               st_d    = ST_WR;
               tmr_val = CW'(WP_C - 1);
            end else begin
               st_d    = ST_RD;
               tmr_val = CW'(ACC_C - 1);
            end
         end
         ST_TURN: if (tmr_zero) begin
            st_d     = ST_WR;
            tmr_load = 1'b1;
            tmr_val  = CW'(WP_C - 1);
         end
         ST_RD: if (tmr_zero) begin
            st_d     = ST_RDREL;
            tmr_load = 1'b1;
            tmr_val  = CW'(REL_C - 1);
         end
         ST_WR: if (tmr_zero) begin
            st_d     = ST_WRREC;
            tmr_load = 1'b1;
            tmr_val  = CW'(WREC_C - 1);
         end
         ST_RDREL, ST_WRREC: if (tmr_zero) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         rd_last_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_RD && tmr_zero)
            rd_last_q <= 1'b1;
         else if (st_q == ST_WR && tmr_zero)
            rd_last_q <= 1'b0;
      end
   end

   assign state    = st_q;
   assign accept   = (st_q == ST_IDLE) && req;
   assign capture  = (st_q == ST_RD) && tmr_zero;
   assign done_set = tmr_zero && ((st_q == ST_RD) || (st_q == ST_WR));

endmodule

// File: rtl/asram_strobe.sv
module asram_strobe
   import asram_pkg::*;
(
   input  asram_state_e state,
   output logic         cs_n,
   output logic         oe_n,
   output logic         we_n,
   output logic         dq_oe,
   output logic         idle
);

   always_comb begin
      cs_n  = 1'b1;
      oe_n  = 1'b1;
      we_n  = 1'b1;
      dq_oe = 1'b0;
      idle  = 1'b0;
      unique case (state)
         ST_IDLE:  idle  = 1'b1;
         ST_RD:    begin cs_n = 1'b0; oe_n = 1'b0; end
         ST_WR:    begin cs_n = 1'b0; we_n = 1'b0; dq_oe = 1'b1; end
         ST_WRREC: dq_oe = 1'b1;
         default:  ;
      endcase
   end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int AW = 17,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          capture,
   input  logic          done_set,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] dq_in,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] dq_out,
   output logic [DW-1:0] rdata,
   output logic          done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         dq_out   <= '0;
         rdata    <= '0;
         done     <= 1'b0;
      end else begin
         if (accept) begin
            mem_addr <= addr;
            dq_out   <= wdata;
         end
         if (capture)
            rdata <= dq_in;
         done <= done_set;
      end
   end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 10,
   parameter int GRADE_NS      = 12,
   parameter int TURN_CYC      = 1,
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int ACC_C  = max2(1, cdiv(max2(lim_access(GRADE_NS),
                                   lim_oe_valid(GRADE_NS)), CLK_PERIOD_NS));
   localparam int REL_C  = max2(1, cdiv(lim_oe_off(GRADE_NS), CLK_PERIOD_NS));
   localparam int WP_C   = max2(1, cdiv(max2(lim_wr_pulse(GRADE_NS),
                                   max2(lim_data_setup(GRADE_NS),
                                        lim_addr_to_end(GRADE_NS))), CLK_PERIOD_NS));
   localparam int WREC_C = max2(1, cdiv(lim_wr_cycle(GRADE_NS), CLK_PERIOD_NS) - WP_C);
   localparam int MAXC   = max2(max2(ACC_C, REL_C), max2(max2(WP_C, WREC_C), TURN_CYC));
   localparam int CW     = (MAXC <= 2) ? 1 : $clog2(MAXC);

   generate
      if (GRADE_NS != 12 && GRADE_NS != 15 && GRADE_NS != 20) begin : g_bad_grade
         $error("asram_ctrl: GRADE_NS must be 12, 15 or 20");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("asram_ctrl: CLK_PERIOD_NS must be positive");
      end
      if (TURN_CYC < 1) begin : g_bad_turn
         $error("asram_ctrl: TURN_CYC must be at least 1");
      end
   endgenerate

   asram_state_e  state;
   logic          tmr_load, tmr_zero, accept, capture, done_set;
   logic [CW-1:0] tmr_val;

   asram_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   asram_fsm #(
      .ACC_C  (ACC_C),
      .REL_C  (REL_C),
      .TURN_C (TURN_CYC),
      .WP_C   (WP_C),
      .WREC_C (WREC_C),
      .CW     (CW)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .wr       (wr),
      .tmr_zero (tmr_zero),
      .state    (state),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .accept   (accept),
      .capture  (capture),
      .done_set (done_set)
   );

   asram_strobe u_strobe (
      .state (state),
      .cs_n  (mem_cs_n),
      .oe_n  (mem_oe_n),
      .we_n  (mem_we_n),
      .dq_oe (mem_dq_oe),
      .idle  (ready)
   );

   asram_datapath #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .capture  (capture),
      .done_set (done_set),
      .addr     (addr),
      .wdata    (wdata),
      .dq_in    (mem_dq_in),
      .mem_addr (mem_addr),
      .dq_out   (mem_dq_out),
      .rdata    (rdata),
      .done     (done)
   );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              ready,
   input logic              done,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr
);

   assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

   assert_wr_oe_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   assert_wr_cs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_cs_n);

   assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |=> !mem_dq_oe);

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req) |=> !ready);

   assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |=> (mem_cs_n || $stable(mem_addr)));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .ready     (ready),
   .done      (done),
   .mem_cs_n  (mem_cs_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

   function automatic int up(input int ns, input int per);
      return (ns + per - 1) / per;
   endfunction

   // expected cycle counts at 10 ns clock, 12 ns grade
   localparam int N_ACC  = up(12, 10);
   localparam int N_REL  = (up(5, 10) < 1) ? 1 : up(5, 10);
   localparam int N_TURN = 1;
   localparam int N_WP   = up(8, 10);
   localparam int N_WREC = (up(12, 10) - N_WP < 1) ? 1 : up(12, 10) - N_WP;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, wr = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        ready, done, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  rdata, mem_dq_out, mem_dq_in;
   logic [16:0] mem_addr;

   always #5 clk = ~clk;

   asram_ctrl #(.CLK_PERIOD_NS(10), .GRADE_NS(12)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
      .ready(ready), .done(done), .rdata(rdata),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   // memory model: valid data only from the second output-enabled cycle
   logic [7:0] mem [256];
   int         oe_run = 0;
   always @(posedge clk) begin
      if (!mem_cs_n && !mem_we_n) mem[mem_addr[7:0]] <= mem_dq_out;
      oe_run <= (!mem_cs_n && !mem_oe_n) ? oe_run + 1 : 0;
   end
   always_comb
      mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n && oe_run >= 1)
                  ? mem[mem_addr[7:0]] : 8'hEE;

   typedef struct {
      logic [3:0]  strb;   // {cs_n, oe_n, we_n, dq_oe}
      bit          rdy, dn, chk_a, chk_d, chk_rd;
      logic [16:0] a;
      logic [7:0]  d, rd;
      string       tag;
   } exp_t;

   exp_t       q[$];
   logic [7:0] ref_mem [256];
   bit         cur_idle = 1'b1;
   bit         last_rd = 1'b0;
   string      idle_tag = "R1";
   int         total = 0, bad = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t mk(input logic [3:0] s, input bit dn, input string tag);
      exp_t e;
      e.strb = s; e.rdy = 1'b0; e.dn = dn; e.chk_a = 1'b1; e.a = addr;
      e.chk_d = 1'b0; e.d = wdata; e.chk_rd = 1'b0; e.rd = '0; e.tag = tag;
      return e;
   endfunction

   task automatic push_read();
      exp_t e;
      for (int i = 0; i < N_ACC; i++) q.push_back(mk(4'b0010, 1'b0, "R2"));
      for (int i = 0; i < N_REL; i++) begin
         e = mk(4'b1110, i == 0, (i == 0) ? "R4" : "R6");
         e.chk_rd = (i == 0); e.rd = ref_mem[addr[7:0]];
         q.push_back(e);
      end
      last_rd = 1'b1;
   endtask

   task automatic push_write();
      exp_t e;
      if (last_rd)
         for (int i = 0; i < N_TURN; i++) q.push_back(mk(4'b1110, 1'b0, "R7"));
      for (int i = 0; i < N_WP; i++) begin
         e = mk(4'b0101, 1'b0, "R3"); e.chk_d = 1'b1; q.push_back(e);
      end
      for (int i = 0; i < N_WREC; i++) begin
         e = mk(4'b1111, i == 0, "R9"); e.chk_d = 1'b1; q.push_back(e);
      end
      ref_mem[addr[7:0]] = wdata;
      last_rd = 1'b0;
   endtask

   task automatic maybe_push();
      if (req && cur_idle && q.size() == 0) begin
         if (wr) push_write(); else push_read();
         cur_idle = 1'b0;
      end
   endtask

   task automatic check_cycle();
      exp_t e;
      if (q.size() == 0) begin
         e.strb = 4'b1110; e.rdy = 1'b1; e.dn = 1'b0; e.chk_a = 1'b0;
         e.chk_d = 1'b0; e.chk_rd = 1'b0; e.tag = idle_tag;
         cur_idle = 1'b1;
      end else begin
         e = q.pop_front();
         cur_idle = 1'b0;
      end
      chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe} == e.strb, e.tag, "strobes",
          {28'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, {28'd0, e.strb});
      chk(ready == e.rdy, (e.rdy ? e.tag : "R6"), "ready", ready, e.rdy);
      chk(done == e.dn, "R5", "done", done, e.dn);
      if (e.chk_a) chk(mem_addr == e.a, "R11", "mem_addr", mem_addr, e.a);
      if (e.chk_d) chk(mem_dq_out == e.d, "R8", "dq_out", mem_dq_out, e.d);
      if (e.chk_rd) chk(rdata == e.rd, e.tag, "rdata", rdata, e.rd);
   endtask

   task automatic step();
      @(negedge clk);
      check_cycle();
      maybe_push();
   endtask

   task automatic wait_idle();
      while (!(cur_idle && q.size() == 0)) step();
   endtask

   task automatic txn(input bit w, input logic [16:0] a, input logic [7:0] d);
      wait_idle();
      req = 1'b1; wr = w; addr = a; wdata = d;
      maybe_push();
      step();
      req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ready, done} == 6'b111010,
          "R1", "reset levels",
          {26'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ready, done}, 32'h3A);
      rst_n = 1'b1;
      step();
      // writes, including the address extremes
      txn(1'b1, 17'h00011, 8'hA5);
      txn(1'b1, 17'h1FF22, 8'h3C);
      txn(1'b1, 17'h00000, 8'h81);
      txn(1'b1, 17'h00055, 8'h10);
      // reads, then a write straight after a read (turnaround)
      txn(1'b0, 17'h00011, 8'h00);
      txn(1'b0, 17'h1FF22, 8'h00);
      txn(1'b1, 17'h00033, 8'h5A);
      txn(1'b0, 17'h00033, 8'h00);
      txn(1'b0, 17'h00000, 8'h00);
      // read, idle gap, then write still gets turnaround R7
      repeat (3) step();
      txn(1'b1, 17'h00066, 8'hC3);
      // held request accepted again in each idle cycle (R10)
      wait_idle();
      req = 1'b1; wr = 1'b0; addr = 17'h00066;
      maybe_push();
      repeat (9) step();
      req = 1'b0;
      wait_idle();
      // request raised while busy and dropped before idle is ignored (R10)
      req = 1'b1; wr = 1'b1; addr = 17'h00044; wdata = 8'h99;
      maybe_push();
      step();
      addr = 17'h00055; wdata = 8'h77;
      step();
      req = 1'b0;
      idle_tag = "R10";
      wait_idle();
      step();
      idle_tag = "R1";
      txn(1'b0, 17'h00055, 8'h00);
      txn(1'b0, 17'h00044, 8'h00);
      wait_idle();
      repeat (2) step();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule